// File: doc/BRIEF.md
# Page-Mode External Memory Sequencer

This block turns single-beat requests from an 8-bit core with a 16-bit address space into cycles on an external memory bus. The bus has a dedicated high-address port and a multiplexed low port that carries the low address byte first and data afterwards. Code fetches and data reads and writes share the bus. Each kind of access has its own strobe: a program-store strobe for fetches, and a read or write strobe for data accesses.

The high address byte is held in an external latch. The block re-latches it only when an access moves into a different 256-byte page. An access that stays in the latched page skips the two page-miss cycles. Data accesses also get a configurable number of stretch cycles. Page-miss penalties therefore depend on how data accesses are interleaved with the code page. A data access to another page costs one miss on the way out and a second miss when the next fetch comes back to the code page.

The core raises a request with the address, kind, direction and write data. It holds them until the block returns a one-cycle ready pulse, which for reads carries the read data. The first bus cycle of an access is driven in the same cycle the request appears, so back-to-back requests leave no idle cycle between them.

Top module: `page_bus_seq`

## Requirements
- R1: After reset the strobes, the address-latch strobe, ready and the low-port drive enable are all low, and the latched high byte is invalid. The first access after any reset therefore takes the page-miss path.
- R2: A code fetch whose high byte equals the latched high byte completes in 2 cycles (request-high cycles including the ready cycle). The program-store strobe is high only in the second cycle.
- R3: A data access that hits the latched page completes in 2 + S cycles. S is the 3-bit stretch input (0 to 7) sampled in the address cycle. With S = 1 the access takes 3 cycles.
- R4: A page miss adds exactly 2 cycles before the address cycle. In the first, the address-latch strobe is high for one cycle with the new high byte on the high port. The second is a setup cycle with no strobe.
- R5: The high port changes only in a cycle where the address-latch strobe is high. A fetch that returns to the code page after a data access in another page pays the miss again.
- R6: In the address cycle the low port is driven with the low address byte. For reads and fetches the low port is released during the strobe, and the read data is taken in the final strobe cycle. For writes the write data is driven for every cycle that the write strobe is high.
- R7: At most one of the address-latch, program-store, read and write strobes is high in any cycle. The strobe of an access stays high without a gap through all of its stretch cycles.
- R8: Ready is high for exactly one cycle per access, in the access's last cycle, and only while the request is high. For a read or fetch, the read-data output in that cycle equals the byte returned by memory.
- R9: Code fetches ignore the stretch input. A fetch with S = 7 still takes 2 cycles on a page hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ready |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| req_we | input | 1 | 1 = data write (ignored for fetches) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| cfg_stretch | input | 3 | Stretch cycles for data accesses |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ready |
| ale | output | 1 | High-address latch strobe |
| psen | output | 1 | Program-store strobe (active high) |
| rd_stb | output | 1 | Data read strobe (active high) |
| wr_stb | output | 1 | Data write strobe (active high) |
| p2_out | output | 8 | High-address port |
| p0_out | output | 8 | Multiplexed low port output |
| p0_oe | output | 1 | Low port drive enable |
| p0_in | input | 8 | Low port input from memory |

## Verification
Every access has a fixed length: 2 cycles for a hit fetch, 2 + S for a hit data access, plus 2 on a page miss. That length is the number of cycles the request stays high, and ready is due in its last cycle. The driver computes the expected length from its own model of the latched page and queues it together with the expected read data. It applies inputs just after a rising edge. The monitor samples on falling edges, counts the request-high cycles, and pops and compares the queued item in the cycle where ready is seen. The memory model latches the high byte on the address-latch strobe and the low byte in the address cycle. A missed re-latch or a shifted phase therefore shows up as wrong data as well as a wrong count.

// File: rtl/page_bus_seq.sv
module page_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_code,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [SW-1:0] cfg_stretch,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          psen,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [AW-DW-1:0] p2_out,
  output logic [DW-1:0] p0_out,
  output logic          p0_oe,
  input  logic [DW-1:0] p0_in
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {PH_IDLE, PH_LATCH, PH_SETUP, PH_ADDR, PH_DATA} ph_t;

  ph_t           ph_q, cur;
  logic [SW-1:0] cnt_q;
  logic [HW-1:0] hi_q;
  logic          hi_v;
  logic          miss, is_wr, last;

  assign miss  = !hi_v || (hi_q != req_addr[AW-1:DW]);
  assign is_wr = !req_code && req_we;

  always_comb begin
    cur = PH_IDLE;
    if (req) begin
      if (ph_q == PH_IDLE) cur = miss ? PH_LATCH : PH_ADDR;
      else                 cur = ph_q;
    end
  end

  assign last   = (cur == PH_DATA) && (cnt_q == '0);
  assign ale    = (cur == PH_LATCH);
  assign p2_out = ale ? req_addr[AW-1:DW] : hi_q;
  assign psen   = (cur == PH_DATA) && req_code;
  assign rd_stb = (cur == PH_DATA) && !req_code && !req_we;
  assign wr_stb = (cur == PH_DATA) && is_wr;
  assign p0_oe  = (cur == PH_ADDR) || wr_stb;
  assign p0_out = (cur == PH_ADDR) ? req_addr[DW-1:0] : (wr_stb ? req_wdata : '0);
  assign rdy    = last;
  assign rdata  = (last && !is_wr) ? p0_in : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      hi_q  <= '0;
      hi_v  <= 1'b0;
    end else begin
      case (cur)
        PH_LATCH: begin
          hi_q <= req_addr[AW-1:DW];
          hi_v <= 1'b1;
          ph_q <= PH_SETUP;
        end
        PH_SETUP: ph_q <= PH_ADDR;
        PH_ADDR: begin
          ph_q  <= PH_DATA;
          cnt_q <= req_code ? '0 : cfg_stretch;
        end
        PH_DATA: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale, psen, rd_stb, wr_stb}));

  a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r4_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && req) |=> (!psen && !rd_stb && !wr_stb && !p0_oe));

  a_r5_hi_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |-> $stable(p2_out));

  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> p0_oe);

  a_r8_rdy_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (req && (psen || rd_stb || wr_stb)));

  a_r7_strobe_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    ((psen || rd_stb || wr_stb) && !rdy) |=> (psen || rd_stb || wr_stb));
endmodule

// File: tb/tb_page_bus_seq.sv
`timescale 1ns/1ps
module tb_page_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_code = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [2:0] cfg_stretch = 3'd1;
  logic rdy, ale, psen, rd_stb, wr_stb, p0_oe;
  logic [7:0] rdata, p2_out, p0_out, p0_in;

  always #4 clk = ~clk;

  page_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_code(req_code), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_stretch(cfg_stretch),
    .rdy(rdy), .rdata(rdata), .ale(ale), .psen(psen), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .p2_out(p2_out), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in)
  );

  int tests = 0, fails = 0;

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  logic [7:0] ext_hi = '0, ext_lo = '0;
  logic [7:0] dmem [256];
  logic [7:0] exp_dmem [256];
  initial for (int i = 0; i < 256; i++) begin
    dmem[i] = 8'(i) ^ 8'h5A;
    exp_dmem[i] = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) begin
    if (ale) ext_hi <= p2_out;
    if (p0_oe && !wr_stb) ext_lo <= p0_out;
    if (wr_stb && rdy) dmem[ext_lo] <= p0_out;
  end
  assign p0_in = psen ? code_byte({ext_hi, ext_lo}) : (rd_stb ? dmem[ext_lo] : 8'h00);

  typedef struct {
    int cyc;
    logic [7:0] data;
    logic [7:0] wdata;
    logic is_wr;
    string tag;
  } item_t;
  item_t sbq[$];

  logic [7:0] page = '0;
  bit pv = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit code, input bit we, input logic [15:0] a,
                     input logic [7:0] wd, input logic [2:0] st, input string tag);
    item_t it;
    bit miss;
    miss = !pv || (page != a[15:8]);
    if (miss) begin page = a[15:8]; pv = 1'b1; end
    it.cyc = (miss ? 2 : 0) + 2 + (code ? 0 : int'(st));
    it.is_wr = !code && we;
    it.wdata = wd;
    it.tag = tag;
    it.data = code ? code_byte(a) : exp_dmem[a[7:0]];
    if (it.is_wr) exp_dmem[a[7:0]] = wd;
    sbq.push_back(it);
    @(posedge clk); #1;
    req = 1'b1; req_code = code; req_we = we; req_addr = a;
    req_wdata = wd; cfg_stretch = st;
    do @(negedge clk); while (!rdy);
  endtask

  task automatic go_idle(input int n);
    @(posedge clk); #1;
    req = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  int cyc_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req) cyc_cnt++;
      if (rdy && !req) check(1'b0, "R8 ready without request", 1, 0);
      if (wr_stb && sbq.size() > 0)
        check(p0_oe && p0_out == sbq[0].wdata, "R6 write data held", int'(p0_out), int'(sbq[0].wdata));
      if (req && rdy) begin
        item_t it;
        if (sbq.size() == 0) check(1'b0, "R8 unexpected ready", 1, 0);
        else begin
          it = sbq.pop_front();
          check(cyc_cnt == it.cyc, {it.tag, " cycle count"}, cyc_cnt, it.cyc);
          if (!it.is_wr) check(rdata == it.data, {it.tag, " read data"}, int'(rdata), int'(it.data));
        end
        cyc_cnt = 0;
      end
    end else cyc_cnt = 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!ale && !psen && !rd_stb && !wr_stb && !rdy && !p0_oe, "R1 idle bus in reset",
          int'({ale, psen, rd_stb, wr_stb, rdy, p0_oe}), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!ale && !psen && !rd_stb && !wr_stb && !rdy && !p0_oe, "R1 idle bus after reset",
          int'({ale, psen, rd_stb, wr_stb, rdy, p0_oe}), 0);

    acc(1, 0, 16'h1200, 8'h00, 3'd1, "R1 first fetch miss");
    acc(1, 0, 16'h1201, 8'h00, 3'd1, "R2 fetch hit");
    acc(0, 0, 16'h3410, 8'h00, 3'd1, "R4 data read miss");
    acc(1, 0, 16'h1202, 8'h00, 3'd1, "R5 return miss");
    acc(0, 1, 16'h1280, 8'hC3, 3'd1, "R3 write hit");
    acc(1, 0, 16'h1203, 8'h00, 3'd1, "R2 fetch hit again");
    acc(0, 0, 16'h1280, 8'h00, 3'd1, "R6 read back");
    acc(0, 0, 16'h1281, 8'h00, 3'd0, "R3 zero stretch");
    acc(0, 1, 16'h1290, 8'h5E, 3'd7, "R3 max stretch write");
    acc(1, 0, 16'h1204, 8'h00, 3'd7, "R9 fetch ignores stretch");
    acc(0, 0, 16'h1290, 8'h00, 3'd7, "R7 long read");
    go_idle(3);
    acc(0, 1, 16'h4455, 8'hA7, 3'd2, "R4 write miss");
    acc(0, 0, 16'h4455, 8'h00, 3'd1, "R5 same page hit");
    acc(1, 0, 16'h12FF, 8'h00, 3'd1, "R5 fetch back miss");
    go_idle(2);

    rst_n = 1'b0; pv = 1'b0;
    repeat (2) @(posedge clk); #1; rst_n = 1'b1;
    acc(1, 0, 16'h12FF, 8'h00, 3'd1, "R1 miss after reset");
    acc(1, 0, 16'h1200, 8'h00, 3'd1, "R2 hit after relatch");
    go_idle(3);

    @(negedge clk);
    check(sbq.size() == 0, "R8 one ready per access", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule